// File: doc/BRIEF.md
# Endian-Selectable Aligned Load/Store Lane Unit

This block sits between a processor load/store port and a memory that is organised as 32-bit words with one write enable per byte lane. Each request carries a byte address, an access width (byte, halfword or word), a per-request byte-order select and, for stores, the value to store. The unit turns an accepted request into a word address, a byte-enable mask and store data placed on the correct lanes. For loads, it takes the word the memory returns one cycle later, extracts the addressed bytes, right-justifies them and fills the upper bits with zeros.

Every access must be naturally aligned. A byte access is always legal. A halfword must start on an even address. A word must start on a multiple of four. A request that breaks this rule, or that uses the reserved width code, never reaches the memory. Instead, the unit reports a one-cycle error pulse. Byte order is chosen per request. Little-endian order places the least significant byte at the lowest address. Big-endian order places the most significant byte there. The lanes are mapped so that a value stored in one order reads back correctly in that same order.

The memory-side outputs follow the request combinationally, so a memory with a synchronous read port returns data in the next cycle. Load results and error pulses come from registers and appear one cycle after the request.

Top module: `mau_top`

## Requirements
- R1: For an accepted request, `mem_waddr` equals the byte address shifted right by two bits, in the same cycle as the request.
- R2: Width codes are 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A request is accepted (`mem_en` high) only if its width is not reserved and its address is a multiple of the width in bytes. An accepted request enables exactly as many lanes as it has bytes.
- R3: A rejected request drives `mem_en`, `mem_we` and `mem_be` to zero, so memory is left unchanged. `misalign_err` is high for exactly the following cycle, and no `rd_valid` is produced for it.
- R4: In little-endian mode (`req_big` = 0), the byte at address A uses lane A[1:0], where lane k is bits 8k+7..8k. A halfword covers lanes A[1:0] and A[1:0]+1, with its low byte in the lower lane.
- R5: In big-endian mode (`req_big` = 1), the byte at address A uses lane 3−A[1:0]. A halfword at A[1:0] = 0 covers lanes 3..2 and one at A[1:0] = 2 covers lanes 1..0, with the most significant byte in the higher lane. A word covers all four lanes, with bit 31 on lane 3, in both modes.
- R6: An accepted store raises `mem_we`. It places the low bytes of `req_wdata` on the enabled lanes in the order of R4/R5 and drives zero on the other lanes.
- R7: One cycle after an accepted load, `rd_valid` is high. `rd_data` then holds the addressed bytes, assembled in the requested byte order, right-justified and zero-extended.
- R8: While reset is high, and in the first cycle after it, `rd_valid` and `misalign_err` are low.
- R9: A store produces no `rd_valid` and no `misalign_err`.
- R10: Requests may arrive on consecutive cycles with different byte orders and widths. Each request is mapped and each result is returned using only that request's own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Width code (0 byte, 1 half, 2 word, 3 reserved) |
| req_big | input | 1 | 1 = big-endian, 0 = little-endian |
| req_wdata | input | DATA_W | Store value, right-justified |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_waddr | output | ADDR_W-2 | Word address |
| mem_be | output | DATA_W/8 | Byte-lane enables |
| mem_wdata | output | DATA_W | Lane-placed store data |
| mem_rdata | input | DATA_W | Word from memory, one cycle after `mem_en` |
| rd_valid | output | 1 | Load result valid |
| rd_data | output | DATA_W | Right-justified, zero-extended load result |
| misalign_err | output | 1 | One-cycle pulse for a rejected request |

## Verification
The hardest case to reach is a store and a load to the same bytes in opposite byte orders, issued on back-to-back cycles. Only then does a wrong lane choice corrupt data in a way a single-mode test cannot see. The stimulus is seeded random requests with mixed widths, orders and addresses over a small 64-byte window, so that stores and loads collide often. A reference byte model predicts every lane mask, every placed store word and every loaded value. Directed sequences add each byte lane in both orders, both halfword positions, every misaligned offset, the reserved width, and a store-then-load pair with the order switched on consecutive cycles.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  function automatic int unsigned size_bytes(acc_size_e s);
    case (s)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return 4;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/mau_align_chk.sv
module mau_align_chk
  import mau_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] addr_lo,
  output logic             aligned
);

  logic [OFS_W-1:0] low_mask;

  always_comb begin
    low_mask = OFS_W'(size_bytes(size) - 1);
    aligned  = (size != SZ_RSVD) && ((addr_lo & low_mask) == '0);
  end

endmodule

// File: rtl/mau_lane_map.sv
module mau_lane_map
  import mau_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFS_W  = $clog2(LANES)
) (
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  addr_lo,
  input  logic              big,
  input  logic [DATA_W-1:0] wdata,
  output logic [OFS_W-1:0]  lsb_lane,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lane_wdata
);

  localparam int CNT_W = OFS_W + 1;

  logic [CNT_W-1:0]  nb;
  logic [DATA_W-1:0] val_mask;

  always_comb begin
    nb = CNT_W'(size_bytes(size));
    if (big) lsb_lane = OFS_W'(CNT_W'(LANES) - nb - {1'b0, addr_lo});
    else     lsb_lane = addr_lo;
    val_mask   = (DATA_W'(1) << {nb, 3'b000}) - DATA_W'(1);
    if (nb >= CNT_W'(DATA_W / 8)) val_mask = '1;
    lane_wdata = (wdata & val_mask) << {lsb_lane, 3'b000};
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g] = (CNT_W'(g) >= {1'b0, lsb_lane}) &&
                   (CNT_W'(g) <  ({1'b0, lsb_lane} + nb));
  end

endmodule

// File: rtl/mau_resp_stage.sv
module mau_resp_stage
  import mau_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_rd,
  input  logic              reject,
  input  logic [OFS_W-1:0]  lsb_lane,
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              misalign_err
);

  localparam int CNT_W = OFS_W + 1;

  logic [OFS_W-1:0]  lsb_q;
  acc_size_e         size_q;
  logic [DATA_W-1:0] keep_mask;
  logic [CNT_W-1:0]  nb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid     <= 1'b0;
      misalign_err <= 1'b0;
      lsb_q        <= '0;
      size_q       <= SZ_BYTE;
    end else begin
      rd_valid     <= issue_rd;
      misalign_err <= reject;
      if (issue_rd) begin
        lsb_q  <= lsb_lane;
        size_q <= size;
      end
    end
  end

  always_comb begin
    nb_q      = CNT_W'(size_bytes(size_q));
    keep_mask = (DATA_W'(1) << {nb_q, 3'b000}) - DATA_W'(1);
    if (nb_q >= CNT_W'(DATA_W / 8)) keep_mask = '1;
    rd_data   = (mem_rdata >> {lsb_q, 3'b000}) & keep_mask;
  end

  // R3: an error pulse and a load result never coincide
  p_err_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(misalign_err && rd_valid));

endmodule

// File: rtl/mau_top.sv
module mau_top
  import mau_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFS_W = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [1:0]          req_size,
  input  logic                req_big,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-OFS_W-1:0] mem_waddr,
  output logic [LANES-1:0]    mem_be,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                misalign_err
);

  acc_size_e         sz;
  logic              aligned;
  logic              issue;
  logic [OFS_W-1:0]  lsb_lane;
  logic [LANES-1:0]  be_raw;
  logic [DATA_W-1:0] wd_raw;

  assign sz = acc_size_e'(req_size);

  mau_align_chk #(.OFS_W(OFS_W)) u_align (
    .size    (sz),
    .addr_lo (req_addr[OFS_W-1:0]),
    .aligned (aligned)
  );

  mau_lane_map #(.DATA_W(DATA_W), .LANES(LANES), .OFS_W(OFS_W)) u_map (
    .size       (sz),
    .addr_lo    (req_addr[OFS_W-1:0]),
    .big        (req_big),
    .wdata      (req_wdata),
    .lsb_lane   (lsb_lane),
    .be         (be_raw),
    .lane_wdata (wd_raw)
  );

  assign issue     = req_valid && aligned;
  assign mem_en    = issue;
  assign mem_we    = issue && req_write;
  assign mem_waddr = req_addr[ADDR_W-1:OFS_W];
  assign mem_be    = issue ? be_raw : '0;
  assign mem_wdata = (issue && req_write) ? wd_raw : '0;

  mau_resp_stage #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_resp (
    .clk          (clk),
    .rst          (rst),
    .issue_rd     (issue && !req_write),
    .reject       (req_valid && !aligned),
    .lsb_lane     (lsb_lane),
    .size         (sz),
    .mem_rdata    (mem_rdata),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .misalign_err (misalign_err)
  );

  // R2: lane count matches the access width
  p_lane_count_r2: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> ($countones(mem_be) == int'(size_bytes(sz))));

  // R3: an error pulse follows a request that did not reach memory
  p_err_after_reject_r3: assert property (@(posedge clk) disable iff (rst)
    misalign_err |-> ($past(req_valid) && !$past(mem_en)));

  // R3: no lanes are enabled without an access strobe
  p_idle_no_lanes_r3: assert property (@(posedge clk) disable iff (rst)
    !mem_en |-> (mem_be == '0 && !mem_we));

  // R7: a load result follows an issued load
  p_rd_after_load_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(mem_en) && !$past(mem_we)));

  // R7: byte loads are zero-extended
  p_byte_zext_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(req_size) == 2'd0) |-> (rd_data[DATA_W-1:8] == '0));

  // R5: word accesses cover every lane in either order
  p_word_full_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_en && sz == SZ_WORD) |-> (mem_be == '1));

endmodule

// File: tb/mau_top_tb_top.sv
`timescale 1ns/100ps
module mau_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr  = '0;
  logic [1:0]  req_size  = '0;
  logic        req_big   = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        mem_en, mem_we;
  logic [13:0] mem_waddr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        misalign_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] mem_w [0:15];
  logic [7:0]  sh    [0:15][0:3];

  bit          p_rv, p_err;
  logic [31:0] p_rd;
  string       p_tag;

  always #2.5 clk = ~clk;

  mau_top dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_big(req_big),
    .req_wdata(req_wdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .misalign_err(misalign_err)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int k = 0; k < 4; k++)
          if (mem_be[k]) mem_w[mem_waddr[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
      end else begin
        mem_rdata <= mem_w[mem_waddr[3:0]];
      end
    end
  end

  function automatic int lane_of(int a, bit big);
    return big ? 3 - (a % 4) : (a % 4);
  endfunction

  function automatic int nbytes(int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit legal(int a, int s);
    if (s == 3) return 1'b0;
    return (a % nbytes(s)) == 0;
  endfunction

  function automatic int val_byte(int i, int n, bit big);
    return big ? (n - 1 - i) : i;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, int a, int s, bit big, logic [31:0] d,
                      string tag);
    logic [3:0]  e_be;
    logic [31:0] e_wd, e_rd;
    int          n;
    bit          ok;
    @(negedge clk);
    chk(rd_valid == p_rv, {"R7 R9 rd_valid", p_tag}, 32'(rd_valid), 32'(p_rv));
    chk(misalign_err == p_err, {"R3 misalign_err", p_tag}, 32'(misalign_err), 32'(p_err));
    if (p_rv) chk(rd_data == p_rd, {"R7 rd_data", p_tag}, rd_data, p_rd);
    req_valid = v; req_write = w; req_addr = 16'(a); req_size = 2'(s);
    req_big = big; req_wdata = d;
    n  = nbytes(s);
    ok = legal(a, s);
    e_be = '0; e_wd = '0; e_rd = '0;
    for (int i = 0; i < n; i++) begin
      int ln, vb;
      ln = lane_of(a + i, big);
      vb = val_byte(i, n, big);
      e_be[ln] = 1'b1;
      e_wd[8*ln +: 8] = d[8*vb +: 8];
      e_rd[8*vb +: 8] = sh[((a + i) / 4) % 16][ln];
    end
    #1;
    if (v) begin
      chk(mem_en == ok, {"R2 mem_en", tag}, 32'(mem_en), 32'(ok));
      if (ok) begin
        chk(mem_waddr == 14'(a / 4), {"R1 mem_waddr", tag}, 32'(mem_waddr), 32'(a / 4));
        chk(mem_be == e_be, {big ? "R5 mem_be" : "R4 mem_be", tag}, 32'(mem_be), 32'(e_be));
        chk(mem_we == w, {"R6 mem_we", tag}, 32'(mem_we), 32'(w));
        if (w) begin
          chk(mem_wdata == e_wd, {"R6 mem_wdata", tag}, mem_wdata, e_wd);
          for (int i = 0; i < n; i++)
            sh[((a + i) / 4) % 16][lane_of(a + i, big)] = d[8*val_byte(i, n, big) +: 8];
        end
      end else begin
        chk({mem_en, mem_we, mem_be} == 6'd0, {"R3 quiet", tag},
            32'({mem_en, mem_we, mem_be}), 32'd0);
      end
    end
    p_rv  = v && ok && !w;
    p_err = v && !ok;
    p_rd  = e_rd;
    p_tag = tag;
  endtask

  initial begin
    int unsigned seed_dummy;
    for (int i = 0; i < 16; i++) begin
      mem_w[i] = '0;
      for (int k = 0; k < 4; k++) sh[i][k] = '0;
    end
    p_rv = 1'b0; p_err = 1'b0; p_rd = '0; p_tag = "";
    seed_dummy = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    chk(rd_valid == 1'b0 && misalign_err == 1'b0, "R8 reset outputs",
        32'({rd_valid, misalign_err}), 32'd0);
    chk(mem_en == 1'b0, "R8 idle strobe", 32'(mem_en), 32'd0);
    rst = 1'b0;

    // directed: each byte lane in both orders, store then load
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < 4; a++) begin
        step(1, 1, 8 + a, 0, b[0], 32'hA0 + 32'(a) + 32'(16 * b), " R4 R5 byte");
        step(1, 0, 8 + a, 0, b[0], '0, " R4 R5 byte");
      end
    // halfwords at both positions, both orders
    step(1, 1, 16, 1, 1'b1, 32'h0000_1234, " R5 half0");
    step(1, 1, 18, 1, 1'b1, 32'hFFFF_5678, " R5 half2");
    step(1, 0, 16, 2, 1'b1, '0, " R5 word view");
    step(1, 0, 18, 1, 1'b1, '0, " R5 half2 rd");
    step(1, 1, 20, 1, 1'b0, 32'h0000_9ABC, " R4 half0");
    step(1, 0, 20, 0, 1'b0, '0, " R4 low byte");
    // words, then order switch back to back
    step(1, 1, 24, 2, 1'b0, 32'h1122_3344, " R6 word");
    step(1, 0, 24, 2, 1'b1, '0, " R10 word other order");
    step(1, 1, 28, 1, 1'b1, 32'h0000_CAFE, " R10 st big");
    step(1, 0, 28, 1, 1'b0, '0, " R10 ld little");
    step(1, 0, 28, 1, 1'b1, '0, " R10 ld big");
    // misaligned and reserved width
    step(1, 1, 33, 1, 1'b0, 32'hDEAD_BEEF, " R3 half odd");
    step(1, 0, 34, 2, 1'b1, '0, " R3 word off2");
    step(1, 1, 35, 2, 1'b0, 32'h1, " R3 word off3");
    step(1, 0, 32, 3, 1'b0, '0, " R3 reserved");
    step(1, 0, 32, 2, 1'b0, '0, " R3 memory untouched");
    step(1, 1, 36, 0, 1'b0, 32'h55, " R9 store");
    step(0, 0, 0, 0, 1'b0, '0, " R9 idle");

    // seeded random mix
    for (int t = 0; t < 600; t++) begin
      int a, s;
      a = int'($urandom % 64);
      s = int'($urandom % 4);
      step(($urandom % 8) != 0, ($urandom % 2) == 1, a, s,
           ($urandom % 2) == 1, $urandom, " random");
    end
    step(0, 0, 0, 0, 1'b0, '0, " drain");
    step(0, 0, 0, 0, 1'b0, '0, " drain");
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule